// File: doc/BRIEF.md
# AES Round-Key Schedule Builder

This block turns an AES cipher key of 128, 192 or 256 bits into the complete set of round keys for encryption. In the same run it also builds a second set for decryption in equivalent-inverse-cipher form. In that second set, every round key strictly between the first and the last goes through InvMixColumns, and the round keys are stored last round first. A cipher datapath next to it reads both sets one 32-bit word at a time, each through its own address port.

A one-cycle start pulse loads the key words and the key length in bytes. The block then produces one schedule word per clock cycle: first the encryption words, then the decryption words. It holds busy high for the whole run and then pulses done for one cycle. A key length it cannot use sets an error flag, and the block starts no work. The S-box, built from the inverse in GF(2^8) followed by the affine map, and the round constants are computed in logic. The block holds no tables.

Top module: `aeskx_top`

## Requirements
- R1: A start pulse accepted while idle with key length 16, 24 or 32 bytes starts a run and clears the error flag. With any other length it sets the error flag from the next cycle on, starts no run, and leaves the round count and both schedules unchanged.
- R2: After an accepted start, the round count output reads 10, 12 or 14 and the key-size code reads 0, 1 or 2, for 16, 24 and 32 byte keys. After reset both read 0.
- R3: Key word k sits at bits 32k+31..32k of the key bus and is little-endian, so its least significant byte is key byte 4k. Encryption words 0..Nk-1 equal the key words, where Nk is the key length divided by 4.
- R4: Each further encryption word i is word i-Nk XOR a running term. When i is a multiple of Nk, that term is word i-1 rotated right by 8 bits, with each byte passed through the S-box, and the round constant XORed into the low byte. The round constants are 01, then each previous one doubled in GF(2^8) modulo 0x11B. In all other positions the term is word i-1 itself.
- R5: With a 32-byte key, a word whose position within its 8-word group is 4 uses the S-box of word i-1 as its term, with no rotation and no constant.
- R6: Decryption slots 0..3 hold encryption round key Nr. For g from 1 to Nr-1, slots 4g..4g+3 hold InvMixColumns of encryption round key Nr-g, with byte 0 as the column's first row. Slots 4Nr..4Nr+3 hold encryption words 0..3 unchanged.
- R7: Busy rises on the edge that accepts start and stays high for exactly (4(Nr+1)-Nk)+4(Nr+1) cycles. Done is high for exactly the one cycle after busy falls, and only then.
- R8: A start pulse while busy is ignored. The run in progress completes with the original key and length.
- R9: Read addresses at or beyond 4(Nr+1) return zero on both ports, as does every address after reset and before the first accepted run. Words left over from an earlier, longer key therefore read as zero.
- R10: Both read ports are combinational: the word for an address appears in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to expand the key on keyFlat |
| keyLen | input | 6 | Key length in bytes |
| keyFlat | input | 256 | Eight 32-bit key words, word k at bits 32k+31..32k |
| busy | output | 1 | High while the schedules are being built |
| done | output | 1 | One-cycle pulse when both schedules are complete |
| err | output | 1 | Set by a start with an unusable length |
| rounds | output | 4 | Round count Nr of the stored schedule |
| keySize | output | 2 | Key-size code of the stored schedule |
| encAddr | input | 6 | Encryption schedule read address |
| encWord | output | 32 | Encryption schedule word |
| decAddr | input | 6 | Decryption schedule read address |
| decWord | output | 32 | Decryption schedule word |

## Verification
The assertions check, on every cycle, the control contract. They cover the done pulse and where it falls relative to busy, the handling of good and bad lengths at start, the round count staying stable while busy, the pairing of round count and size code, and the zero returned by out-of-range reads on both ports. Whether the words are right can only be shown by the bench's scenarios. These are the three published expansion examples, a zero key, a start ignored during a run, a shorter key after a longer one, and a sweep over every length value. The bench compares every address of both schedules against a byte-level model.

// File: rtl/aeskx_pkg.sv
package aeskx_pkg;
  localparam int WORD_W      = 32;
  localparam int MAX_KEY_WDS = 8;
  localparam int SCHED_WDS   = 60;
  localparam int IDX_W       = $clog2(SCHED_WDS);
  localparam int KEY_BITS    = WORD_W * MAX_KEY_WDS;

  typedef struct packed {
    logic             loadKey;
    logic             encWr;
    logic             decWr;
    logic [IDX_W-1:0] idx;
    logic [2:0]       pos;
    logic [3:0]       grp;
  } kxStrobe_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // a^254 is the inverse of a (0 stays 0)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] p, r;
    p = a;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gfMul(p, p);
      r = gfMul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gfInv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] subWord(input logic [31:0] w);
    logic [31:0] o;
    for (int i = 0; i < 4; i++) o[8*i +: 8] = sbox(w[8*i +: 8]);
    return o;
  endfunction

  function automatic logic [7:0] rconOf(input logic [3:0] g);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 0; k < 10; k++) if (4'(k) < g) r = xtime(r);
    return r;
  endfunction

  function automatic logic [31:0] invMixCol(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    a0 = w[7:0]; a1 = w[15:8]; a2 = w[23:16]; a3 = w[31:24];
    return {gfMul(a0, 8'h0b) ^ gfMul(a1, 8'h0d) ^ gfMul(a2, 8'h09) ^ gfMul(a3, 8'h0e),
            gfMul(a0, 8'h0d) ^ gfMul(a1, 8'h09) ^ gfMul(a2, 8'h0e) ^ gfMul(a3, 8'h0b),
            gfMul(a0, 8'h09) ^ gfMul(a1, 8'h0e) ^ gfMul(a2, 8'h0b) ^ gfMul(a3, 8'h0d),
            gfMul(a0, 8'h0e) ^ gfMul(a1, 8'h0b) ^ gfMul(a2, 8'h0d) ^ gfMul(a3, 8'h09)};
  endfunction
endpackage

// File: rtl/aeskx_ctrl.sv
module aeskx_ctrl
  import aeskx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [5:0] keyLen,
  output kxStrobe_t  strb,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [3:0] nr,
  output logic [3:0] nk,
  output logic [1:0] keySize
);
  typedef enum logic [1:0] {S_IDLE, S_ENC, S_DEC} kxState_e;

  kxState_e         state;
  logic [IDX_W-1:0] idx;
  logic [2:0]       pos;
  logic [3:0]       grp;
  logic             lenOk;
  logic [3:0]       reqNr, reqNk;
  logic [1:0]       reqKs;
  logic [IDX_W-1:0] lastIdx;

  always_comb begin
    lenOk = 1'b1;
    reqNr = 4'd10; reqNk = 4'd4; reqKs = 2'd0;
    case (keyLen)
      6'd16: begin reqNr = 4'd10; reqNk = 4'd4; reqKs = 2'd0; end
      6'd24: begin reqNr = 4'd12; reqNk = 4'd6; reqKs = 2'd1; end
      6'd32: begin reqNr = 4'd14; reqNk = 4'd8; reqKs = 2'd2; end
      default: lenOk = 1'b0;
    endcase
  end

  assign lastIdx = {nr, 2'b11};
  assign busy    = (state != S_IDLE);

  always_comb begin
    strb.loadKey = (state == S_IDLE) && start && lenOk;
    strb.encWr   = (state == S_ENC);
    strb.decWr   = (state == S_DEC);
    strb.idx     = idx;
    strb.pos     = pos;
    strb.grp     = grp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; idx <= '0; pos <= '0; grp <= '0;
      done <= 1'b0; err <= 1'b0;
      nr <= '0; nk <= 4'd4; keySize <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (lenOk) begin
            nr <= reqNr; nk <= reqNk; keySize <= reqKs;
            err <= 1'b0;
            idx <= IDX_W'(reqNk);
            pos <= '0; grp <= '0;
            state <= S_ENC;
          end else begin
            err <= 1'b1;
          end
        end
        S_ENC: begin
          if (idx == lastIdx) begin
            idx <= '0;
            state <= S_DEC;
          end else begin
            idx <= idx + 1'b1;
            if ({1'b0, pos} == nk - 4'd1) begin
              pos <= '0;
              grp <= grp + 1'b1;
            end else begin
              pos <= pos + 1'b1;
            end
          end
        end
        S_DEC: begin
          if (idx == lastIdx) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aeskx_dp.sv
module aeskx_dp
  import aeskx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  kxStrobe_t           strb,
  input  logic [KEY_BITS-1:0] keyFlat,
  input  logic [3:0]          nr,
  input  logic [3:0]          nk,
  input  logic [IDX_W-1:0]    encAddr,
  input  logic [IDX_W-1:0]    decAddr,
  output logic [WORD_W-1:0]   encWord,
  output logic [WORD_W-1:0]   decWord
);
  logic [WORD_W-1:0] encArr [SCHED_WDS];
  logic [WORD_W-1:0] decArr [SCHED_WDS];

  logic [IDX_W-1:0]  prevIdx, backIdx, srcIdx;
  logic [WORD_W-1:0] prevWord, backWord, termWord, newWord, rawWord, decVal;
  logic [3:0]        slotGrp, srcGrp;
  logic [IDX_W:0]    limit;

  assign prevIdx  = strb.idx - 1'b1;
  assign backIdx  = strb.idx - IDX_W'(nk);
  assign prevWord = encArr[prevIdx];
  assign backWord = encArr[backIdx];

  always_comb begin
    termWord = prevWord;
    if (strb.pos == 3'd0)
      termWord = subWord({prevWord[7:0], prevWord[31:8]}) ^ {24'h0, rconOf(strb.grp)};
    else if (nk == 4'd8 && strb.pos == 3'd4)
      termWord = subWord(prevWord);
    newWord = termWord ^ backWord;
  end

  assign slotGrp = strb.idx[IDX_W-1:2];
  assign srcGrp  = (slotGrp == 4'd0) ? nr : nr - slotGrp;
  assign srcIdx  = {srcGrp, strb.idx[1:0]};
  assign rawWord = encArr[srcIdx];
  assign decVal  = (slotGrp == 4'd0 || slotGrp == nr) ? rawWord : invMixCol(rawWord);

  assign limit   = (nr == 4'd0) ? '0 : {1'b0, nr + 4'd1, 2'b00};
  assign encWord = ({1'b0, encAddr} < limit) ? encArr[encAddr] : '0;
  assign decWord = ({1'b0, decAddr} < limit) ? decArr[decAddr] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SCHED_WDS; i++) begin
        encArr[i] <= '0;
        decArr[i] <= '0;
      end
    end else begin
      if (strb.loadKey)
        for (int k = 0; k < MAX_KEY_WDS; k++) encArr[k] <= keyFlat[WORD_W*k +: WORD_W];
      if (strb.encWr) encArr[strb.idx] <= newWord;
      if (strb.decWr) decArr[strb.idx] <= decVal;
    end
  end
endmodule

// File: rtl/aeskx_top.sv
module aeskx_top
  import aeskx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [5:0]          keyLen,
  input  logic [KEY_BITS-1:0] keyFlat,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [3:0]          rounds,
  output logic [1:0]          keySize,
  input  logic [IDX_W-1:0]    encAddr,
  output logic [WORD_W-1:0]   encWord,
  input  logic [IDX_W-1:0]    decAddr,
  output logic [WORD_W-1:0]   decWord
);
  kxStrobe_t  strb;
  logic [3:0] nk;

  aeskx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .keyLen(keyLen), .strb(strb),
    .busy(busy), .done(done), .err(err), .nr(rounds), .nk(nk), .keySize(keySize)
  );

  aeskx_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .keyFlat(keyFlat), .nr(rounds), .nk(nk),
    .encAddr(encAddr), .decAddr(decAddr), .encWord(encWord), .decWord(decWord)
  );
endmodule

// File: rtl/aeskx_chk.sv
module aeskx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [5:0]  keyLen,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [3:0]  rounds,
  input logic [1:0]  keySize,
  input logic [5:0]  encAddr,
  input logic [31:0] encWord,
  input logic [5:0]  decAddr,
  input logic [31:0] decWord
);
  logic       goodLen;
  logic [6:0] lim;
  assign goodLen = (keyLen == 6'd16) || (keyLen == 6'd24) || (keyLen == 6'd32);
  assign lim     = (rounds == 4'd0) ? 7'd0 : {1'b0, rounds + 4'd1, 2'b00};

  p_good_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && goodLen) |=> (busy && !err));
  p_bad_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !goodLen) |=> (err && !busy && $stable(rounds)));
  p_size_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rounds == 4'd0 && keySize == 2'd0) || (rounds == 4'd10 && keySize == 2'd0) ||
    (rounds == 4'd12 && keySize == 2'd1) || (rounds == 4'd14 && keySize == 2'd2));
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(rounds));
  p_enc_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, encAddr} >= lim) |-> (encWord == 32'h0));
  p_dec_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, decAddr} >= lim) |-> (decWord == 32'h0));
endmodule

bind aeskx_top aeskx_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .keyLen(keyLen), .busy(busy), .done(done),
  .err(err), .rounds(rounds), .keySize(keySize), .encAddr(encAddr), .encWord(encWord),
  .decAddr(decAddr), .decWord(decWord)
);

// File: tb/sim_aeskx_top.sv
module sim_aeskx_top;
  logic         clk = 1'b0;
  logic         rstN, start;
  logic [5:0]   keyLen, encAddr, decAddr;
  logic [255:0] keyFlat;
  logic         busy, done, err;
  logic [3:0]   rounds;
  logic [1:0]   keySize;
  logic [31:0]  encWord, decWord;

  always #4 clk = ~clk;

  aeskx_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .keyLen(keyLen), .keyFlat(keyFlat),
    .busy(busy), .done(done), .err(err), .rounds(rounds), .keySize(keySize),
    .encAddr(encAddr), .encWord(encWord), .decAddr(decAddr), .decWord(decWord)
  );

  int nChecks = 0, nErr = 0;
  logic [7:0]  sbT [256];
  logic [31:0] mEnc [64];
  logic [31:0] mDec [64];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic buildSbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 0, s;
      for (int b = 1; b < 256; b++) if (gm(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      sbT[a] = s;
    end
  endtask

  // byte-level model of both schedules
  task automatic model(input int lenB, input logic [255:0] kf);
    logic [7:0] eb [240];
    logic [7:0] t [4];
    logic [7:0] rc = 8'h01;
    int nk = lenB / 4, nr = nk + 6, tot = 4 * (nk + 7);
    for (int i = 0; i < 4 * nk; i++) eb[i] = kf[8*i +: 8];
    for (int i = nk; i < tot; i++) begin
      for (int b = 0; b < 4; b++) t[b] = eb[4*(i-1)+b];
      if (i % nk == 0) begin
        logic [7:0] f = t[0];
        t[0] = sbT[t[1]] ^ rc; t[1] = sbT[t[2]]; t[2] = sbT[t[3]]; t[3] = sbT[f];
        rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
      end else if (nk == 8 && i % nk == 4) begin
        for (int b = 0; b < 4; b++) t[b] = sbT[t[b]];
      end
      for (int b = 0; b < 4; b++) eb[4*i+b] = eb[4*(i-nk)+b] ^ t[b];
    end
    for (int w = 0; w < 64; w++) begin mEnc[w] = 0; mDec[w] = 0; end
    for (int w = 0; w < tot; w++) mEnc[w] = {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};
    for (int g = 0; g <= nr; g++) begin
      int src = (g == 0) ? nr : nr - g;
      for (int c = 0; c < 4; c++) begin
        logic [7:0] a0 = eb[16*src+4*c], a1 = eb[16*src+4*c+1], a2 = eb[16*src+4*c+2], a3 = eb[16*src+4*c+3];
        if (g == 0 || g == nr) mDec[4*g+c] = {a3, a2, a1, a0};
        else mDec[4*g+c] = {gm(a0,8'h0b)^gm(a1,8'h0d)^gm(a2,8'h09)^gm(a3,8'h0e),
                            gm(a0,8'h0d)^gm(a1,8'h09)^gm(a2,8'h0e)^gm(a3,8'h0b),
                            gm(a0,8'h09)^gm(a1,8'h0e)^gm(a2,8'h0b)^gm(a3,8'h0d),
                            gm(a0,8'h0e)^gm(a1,8'h0b)^gm(a2,8'h0d)^gm(a3,8'h09)};
      end
    end
  endtask

  task automatic compareAll(input string tag);
    for (int a = 0; a < 64; a++) begin
      encAddr = 6'(a); decAddr = 6'(a);
      @(negedge clk);
      check((a < 4) ? "R3" : "R4", $sformatf("%s enc[%0d]", tag, a), encWord, mEnc[a]);
      check("R6", $sformatf("%s dec[%0d]", tag, a), decWord, mDec[a]);
    end
  endtask

  // start a run; optionally pulse start again mid-run with other inputs (R8)
  task automatic runKey(input int lenB, input logic [255:0] kf, input bit disturb, input string tag);
    int cnt = 0, nk = lenB / 4, nr = nk + 6;
    @(negedge clk);
    keyLen = 6'(lenB); keyFlat = kf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", {tag, " busy after start"}, 32'(busy), 32'd1);
    while (busy && cnt < 1000) begin
      cnt++;
      start = disturb && (cnt == 5);
      if (disturb) begin keyLen = 6'd16; keyFlat = ~kf; end
      @(negedge clk);
    end
    start = 1'b0; keyFlat = kf; keyLen = 6'(lenB);
    check("R7", {tag, " busy cycles"}, 32'(cnt), 32'((4*(nr+1)-nk) + 4*(nr+1)));
    check("R7", {tag, " done pulse"}, 32'(done), 32'd1);
    @(negedge clk);
    check("R7", {tag, " done one cycle"}, 32'(done), 32'd0);
    check("R2", {tag, " rounds"}, 32'(rounds), 32'(nr));
    check("R2", {tag, " key size"}, 32'(keySize), 32'((lenB - 16) / 8));
    check("R1", {tag, " err clear"}, 32'(err), 32'd0);
    model(lenB, kf);
    compareAll(tag);
  endtask

  function automatic logic [255:0] packKey(input logic [31:0] k0, k1, k2, k3, k4, k5, k6, k7);
    return {bswap(k7), bswap(k6), bswap(k5), bswap(k4), bswap(k3), bswap(k2), bswap(k1), bswap(k0)};
  endfunction

  initial begin
    #(8 * 150000);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [255:0] k128, k192, k256;
    rstN = 1'b0; start = 1'b0; keyLen = 0; keyFlat = 0; encAddr = 0; decAddr = 0;
    buildSbox();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", "reset rounds", 32'(rounds), 0);
    check("R2", "reset key size", 32'(keySize), 0);
    check("R7", "reset busy/done", {30'b0, busy, done}, 0);
    check("R1", "reset err", 32'(err), 0);
    encAddr = 6'd5; decAddr = 6'd0;
    #1;
    check("R9", "reset enc read", encWord, 0);
    check("R9", "reset dec read", decWord, 0);

    k128 = packKey(32'h2b7e1516, 32'h28aed2a6, 32'habf71588, 32'h09cf4f3c, 0, 0, 0, 0);
    runKey(16, k128, 0, "k128");
    encAddr = 6'd4; decAddr = 6'd0; #1;
    check("R4", "k128 w4", encWord, bswap(32'ha0fafe17));
    encAddr = 6'd43; #1;
    check("R4", "k128 w43", encWord, bswap(32'hb6630ca6));
    check("R6", "k128 dec0 is last round key", decWord, bswap(32'hd014f9a8));
    encAddr = 6'd0; #1;
    check("R10", "same-cycle read word0", encWord, k128[31:0]);

    k192 = packKey(32'h8e73b0f7, 32'hda0e6452, 32'hc810f32b, 32'h809079e5, 32'h62f8ead2, 32'h522c6b7b, 0, 0);
    runKey(24, k192, 0, "k192");
    encAddr = 6'd51; #1;
    check("R4", "k192 w51", encWord, bswap(32'h01002202));

    k256 = packKey(32'h603deb10, 32'h15ca71be, 32'h2b73aef0, 32'h857d7781,
                   32'h1f352c07, 32'h3b6108d7, 32'h2d9810a3, 32'h0914dff4);
    runKey(32, k256, 0, "k256");
    encAddr = 6'd12; #1;
    check("R5", "k256 w12", encWord, bswap(32'ha8b09c1a));
    encAddr = 6'd59; #1;
    check("R5", "k256 w59", encWord, bswap(32'h706c631e));

    // shorter key after longer: words 44..59 must read zero (R9)
    runKey(16, '0, 0, "zero128");
    encAddr = 6'd4; #1;
    check("R4", "zero key w4", encWord, bswap(32'h62636363));
    encAddr = 6'd50; decAddr = 6'd50; #1;
    check("R9", "stale enc word hidden", encWord, 0);
    check("R9", "stale dec word hidden", decWord, 0);

    // every unusable length value (R1)
    for (int l = 0; l < 64; l++) begin
      if (l == 16 || l == 24 || l == 32) continue;
      @(negedge clk);
      keyLen = 6'(l); keyFlat = ~k128; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R1", $sformatf("len %0d err", l), 32'(err), 1);
      check("R1", $sformatf("len %0d no run", l), 32'(busy), 0);
      check("R1", $sformatf("len %0d rounds kept", l), 32'(rounds), 10);
      encAddr = 6'd7; #1;
      check("R1", $sformatf("len %0d schedule kept", l), encWord, mEnc[7]);
    end

    // start ignored while busy (R8)
    runKey(32, k256, 1, "k256 disturbed");
    runKey(24, {64'h0, {192{1'b1}}}, 0, "ones192");
    check("R8", "rounds after ignored start", 32'(rounds), 12);

    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule